// File: doc/BRIEF.md
# SYSREF Pulse Qualifier and Window Monitor

This block sits behind a SYSREF input that has already been sampled into the sample-clock domain. It finds rising edges and decides which of them go on as single-cycle alignment events. The decision follows a 3-bit policy code. The code can block every pulse, pass every pulse, or drop the first one or two pulses after the counter starts and then pass either just the next pulse or every later pulse.

A pulse counter controls the policy. A clear control resets the counter, arms the path and loads the policy code. A start control, given either as a register level or as a GPIO strobe that can be enabled, lets the counter run.

The block also watches a set of timing-window flags. These come from detectors outside the block. On every SYSREF rising edge the block captures the whole flag set, replacing the old values, and it keeps a registered OR of the captured flags.

Top module: `sysref_qualifier`

## Requirements
- R1: After reset, `align_pulse`, `pulse_count`, `win_flags` and `win_any` are all zero, and the active policy is code 0.
- R2: A rising edge means `sref_in` is 1 in a cycle and was 0 in the cycle before. A forwarded edge raises `align_pulse` for exactly one cycle, starting at the clock edge after the edge is seen. An input held high gives at most one pulse.
- R3: With active policy code 1, every counted edge is forwarded. With codes 0, 2 and 7, no edge is ever forwarded.
- R4: Code 3 forwards only the second counted edge after a start, and code 5 forwards only the third. After that, nothing is forwarded until the next clear.
- R5: Code 4 forwards every counted edge from the second one on. Code 6 forwards every counted edge from the third one on.
- R6: While `ctr_clear` is high, the counter is zero and stopped. A clear also arms the path. A start given before the first clear after reset has no effect. When clear and start are high in the same cycle, the clear wins.
- R7: The counter starts on `ctr_start`, or on `gpio_start` when `gpio_start_en` is 1. When `gpio_start_en` is 0, `gpio_start` is ignored.
- R8: `pulse_count` goes up by one for each rising edge seen while the counter runs, and it stops at 2^CW-1 instead of wrapping.
- R9: On every rising edge, whether or not the counter runs, `win_flags` takes the value of `win_flags_in`. In any cycle without an edge, `win_flags` keeps its value.
- R10: `win_any` is 1 exactly when at least one captured window flag is 1.
- R11: The active policy is loaded from `mode_cfg` only while `ctr_clear` is high. Changing `mode_cfg` at any other time has no effect until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sref_in | input | 1 | Sampled SYSREF level |
| mode_cfg | input | 3 | Pulse policy code, loaded on clear |
| ctr_clear | input | 1 | Clears the counter, arms the path, loads the policy |
| ctr_start | input | 1 | Register start of the counter |
| gpio_start | input | 1 | External start strobe |
| gpio_start_en | input | 1 | Lets `gpio_start` act as a start |
| win_flags_in | input | NWIN | Timing-window detector outputs |
| align_pulse | output | 1 | Forwarded alignment event |
| pulse_count | output | CW | Counted SYSREF edges |
| win_flags | output | NWIN | Window flags captured at the last edge |
| win_any | output | 1 | OR of the captured window flags |

## Verification
The bench builds the block with CW=4, so the counter saturates at 15 after a short burst of edges. That makes it possible to show that the counter stops at 15 instead of wrapping, and that the use-one policies never fire again once the count has passed their target. NWIN keeps its default of five, which lets the bench try distinct flag patterns, including all-zero, to check both overwrite on each edge and the OR summary. All eight policy codes are run through the same burst of five edges, so the number of forwarded pulses can be compared against a value worked out by hand for each code.

// File: rtl/sysref_qualifier.sv
module sysref_qualifier #(
  parameter int NWIN = 5,
  parameter int CW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sref_in,
  input  logic [2:0]      mode_cfg,
  input  logic            ctr_clear,
  input  logic            ctr_start,
  input  logic            gpio_start,
  input  logic            gpio_start_en,
  input  logic [NWIN-1:0] win_flags_in,
  output logic            align_pulse,
  output logic [CW-1:0]   pulse_count,
  output logic [NWIN-1:0] win_flags,
  output logic            win_any
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic       sref_q;
  logic       armed;
  logic       running;
  logic [2:0] mode_act;
  logic [1:0] skip_n;
  logic       use_all;
  logic       use_any;
  logic       edge_seen;
  logic       start_req;
  logic       fwd;

  assign edge_seen = sref_in & ~sref_q;
  assign start_req = ctr_start | (gpio_start_en & gpio_start);

  always_comb begin
    skip_n  = 2'd0;
    use_all = 1'b0;
    use_any = 1'b1;
    case (mode_act)
      3'd1:    use_all = 1'b1;
      3'd3:    skip_n  = 2'd1;
      3'd4:    begin skip_n = 2'd1; use_all = 1'b1; end
      3'd5:    skip_n  = 2'd2;
      3'd6:    begin skip_n = 2'd2; use_all = 1'b1; end
      default: use_any = 1'b0;
    endcase
  end

  assign fwd = edge_seen & running & ~ctr_clear & use_any &
               (use_all ? (pulse_count >= CW'(skip_n)) : (pulse_count == CW'(skip_n)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sref_q      <= 1'b0;
      armed       <= 1'b0;
      running     <= 1'b0;
      mode_act    <= 3'd0;
      pulse_count <= '0;
      align_pulse <= 1'b0;
      win_flags   <= '0;
      win_any     <= 1'b0;
    end else begin
      sref_q      <= sref_in;
      align_pulse <= fwd;
      if (edge_seen) begin
        win_flags <= win_flags_in;
        win_any   <= |win_flags_in;
      end
      if (ctr_clear) begin
        pulse_count <= '0;
        running     <= 1'b0;
        armed       <= 1'b1;
        mode_act    <= mode_cfg;
      end else begin
        if (edge_seen && running && pulse_count != CNT_MAX)
          pulse_count <= pulse_count + 1'b1;
        if (start_req && armed)
          running <= 1'b1;
      end
    end
  end
endmodule

module sysref_qualifier_chk #(
  parameter int NWIN = 5,
  parameter int CW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sref_in,
  input logic            ctr_clear,
  input logic [2:0]      mode_act,
  input logic            align_pulse,
  input logic [CW-1:0]   pulse_count,
  input logic [NWIN-1:0] win_flags,
  input logic            win_any
);
  logic prev_s;
  always_ff @(posedge clk) prev_s <= rst_n ? sref_in : 1'b0;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    align_pulse |=> !align_pulse); // R2
  AST_PULSE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    align_pulse |-> ($past(sref_in) && !$past(prev_s))); // R2
  AST_DEAD_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    align_pulse |-> !($past(mode_act) inside {3'd0, 3'd2, 3'd7})); // R3
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_clear |=> (pulse_count == '0) && !align_pulse); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_count == {CW{1'b1}}) && !ctr_clear |=> (pulse_count == {CW{1'b1}})); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sref_in && !prev_s) |=> $stable(win_flags)); // R9
  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    win_any == (|win_flags)); // R10
endmodule

bind sysref_qualifier sysref_qualifier_chk #(.NWIN(NWIN), .CW(CW)) chk_i (.*);

// File: tb/sysref_qualifier_tb.sv
module sysref_qualifier_tb_top;
  localparam int NWIN = 5;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic sref_in = 0, ctr_clear = 0, ctr_start = 0, gpio_start = 0, gpio_start_en = 0;
  logic [2:0] mode_cfg = 0;
  logic [NWIN-1:0] win_flags_in = 0;
  logic align_pulse, win_any;
  logic [CW-1:0] pulse_count;
  logic [NWIN-1:0] win_flags;

  int checks = 0, failures = 0, pulses = 0;

  sysref_qualifier #(.NWIN(NWIN), .CW(CW)) dut_i (.*);

  always #10 clk = ~clk;

  // behavioural reference
  int m_prev, m_en, m_run, m_mode, m_cnt, m_align, m_flags, m_any;
  always @(posedge clk) begin
    int e, skip, all, live, f;
    if (!rst_n) begin
      m_prev = 0; m_en = 0; m_run = 0; m_mode = 0; m_cnt = 0;
      m_align = 0; m_flags = 0; m_any = 0;
    end else begin
      e = (sref_in && !m_prev) ? 1 : 0;
      skip = (m_mode == 3 || m_mode == 4) ? 1 : (m_mode == 5 || m_mode == 6) ? 2 : 0;
      all  = (m_mode == 1 || m_mode == 4 || m_mode == 6) ? 1 : 0;
      live = (m_mode == 1 || (m_mode >= 3 && m_mode <= 6)) ? 1 : 0;
      f = 0;
      if (e && m_run && !ctr_clear && live)
        f = all ? (m_cnt >= skip) : (m_cnt == skip);
      m_align = f;
      if (e) begin m_flags = win_flags_in; m_any = (win_flags_in != 0); end
      if (ctr_clear) begin
        m_cnt = 0; m_run = 0; m_en = 1; m_mode = mode_cfg;
      end else begin
        if (e && m_run && m_cnt < CMAX) m_cnt++;
        if ((ctr_start || (gpio_start_en && gpio_start)) && m_en) m_run = 1;
      end
      m_prev = sref_in;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (align_pulse) pulses++;
    checks++;
    if (align_pulse !== m_align[0]) begin failures++;
      $display("FAIL R2 align_pulse actual=%0b expected=%0d", align_pulse, m_align); end
    if (pulse_count !== CW'(m_cnt)) begin failures++;
      $display("FAIL R8 pulse_count actual=%0d expected=%0d", pulse_count, m_cnt); end
    if (win_flags !== NWIN'(m_flags)) begin failures++;
      $display("FAIL R9 win_flags actual=%b expected=%b", win_flags, NWIN'(m_flags)); end
    if (win_any !== m_any[0]) begin failures++;
      $display("FAIL R10 win_any actual=%0b expected=%0d", win_any, m_any); end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sref_edge(logic [NWIN-1:0] fl);
    sref_in = 1; win_flags_in = fl; step();
    win_flags_in = ~fl; step();
    sref_in = 0; step(2);
  endtask

  task automatic do_clear(logic [2:0] m);
    mode_cfg = m; ctr_clear = 1; step(); ctr_clear = 0;
  endtask

  task automatic do_start();
    ctr_start = 1; step(); ctr_start = 0; step();
  endtask

  task automatic burst(int n);
    for (int i = 0; i < n; i++) sref_edge(NWIN'(i + 1));
    step(2);
  endtask

  initial begin
    int exp_m [8] = '{0, 5, 0, 1, 4, 1, 3, 0};
    step(3);
    #8;
    chk("R1 align", align_pulse, 0);
    chk("R1 count", pulse_count, 0);
    chk("R1 flags", win_flags, 0);
    chk("R1 any", win_any, 0);
    @(negedge clk); rst_n = 1; step();

    // R6: start before any clear is ignored
    mode_cfg = 1; do_start(); burst(2);
    chk("R6 start before first clear", pulse_count, 0);
    // R9: flags captured even when counter stopped
    chk("R9 flags on idle edge", win_flags, 2);
    sref_edge(5'b00000);
    chk("R10 all-zero flags", win_any, 0);
    sref_in = 1; win_flags_in = 5'b10100; step();
    win_flags_in = 5'b01011; step(3);
    chk("R9 flags overwritten at edge", win_flags, 5'b10100);
    chk("R9 flags held while high", win_flags, 5'b10100);
    chk("R2 held high one pulse-free count", pulse_count, 0);
    sref_in = 0; step(2);

    // R3 R4 R5: every code
    for (int m = 0; m < 8; m++) begin
      do_clear(3'(m)); do_start();
      pulses = 0;
      burst(5);
      if (m == 3 || m == 5) chk("R4 use-one code", pulses, exp_m[m]);
      else if (m == 4 || m == 6) chk("R5 use-all code", pulses, exp_m[m]);
      else chk("R3 code", pulses, exp_m[m]);
      chk("R8 counted edges", pulse_count, 5);
    end

    // R2: held high input in code 1 gives one pulse
    do_clear(3'd1); do_start(); pulses = 0;
    sref_in = 1; step(6); sref_in = 0; step(3);
    chk("R2 single pulse for long high", pulses, 1);

    // R6: clear wins over start
    do_clear(3'd1); ctr_clear = 1; ctr_start = 1; step(); ctr_clear = 0; ctr_start = 0;
    pulses = 0; burst(2);
    chk("R6 clear beats start", pulse_count, 0);
    chk("R6 no pulses when stopped", pulses, 0);

    // R7: gpio strobe gated by enable
    do_clear(3'd1);
    gpio_start = 1; step(); gpio_start = 0; pulses = 0; burst(2);
    chk("R7 gpio ignored when disabled", pulse_count, 0);
    gpio_start_en = 1; gpio_start = 1; step(); gpio_start = 0; burst(2);
    chk("R7 gpio start", pulses, 2);
    gpio_start_en = 0;

    // R11: mode change takes effect only after clear
    do_clear(3'd1); do_start(); mode_cfg = 0; pulses = 0; burst(3);
    chk("R11 old mode kept", pulses, 3);
    do_clear(3'd0); do_start(); pulses = 0; burst(2);
    chk("R11 new mode after clear", pulses, 0);

    // R8 saturation, R4 no refire after saturation
    do_clear(3'd4); do_start(); pulses = 0; burst(20);
    chk("R8 saturates", pulse_count, CMAX);
    chk("R5 keeps forwarding past saturation", pulses, 19);
    do_clear(3'd3); do_start(); pulses = 0; burst(20);
    chk("R4 single use after saturation", pulses, 1);
    do_clear(3'd1);
    chk("R6 clear zeroes", pulse_count, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule